// File: doc/BRIEF.md
# Bridge Downstream Address Decoder

This block sits at the downstream edge of a host-link to PCI-X bridge. Each request that arrives from the host side carries a 40-bit address and a read/write flag. The block decides whether the bridge claims the request. If it does, the block also decides where the request goes: the secondary bus as a memory or I/O access, or the bridge's own configuration registers. It then produces the secondary-bus command and the translated address.

The bridge's configuration values arrive as plain inputs, held in a register file outside this block. These values are:
- the space enables;
- a 32-bit memory window;
- a 64-bit prefetchable window;
- a 32-bit I/O window;
- the ISA and VGA legacy controls;
- the bridge's unit ID.

Every decision is registered. It appears one clock after the request, together with a one-cycle result-valid pulse.

Top module: `dsd_addr_decoder`

## Requirements
- R1: Latency and idle state. Every output is registered and updates on the clock edge that samples `req_valid` high. `rsp_valid` is high for exactly that one cycle. In cycles with no request, every output is 0. Synchronous reset (`rst_n` low) clears every output.
- R2: Memory claim. A host address in 00_0000_0000h..FC_FFFF_FFFFh is claimed when `mem_en` is 1 and either of two conditions holds. The first is that the address is below 4 GB and inside `mem_base`..`mem_limit`, inclusive. The second is that the zero-extended address is inside `pf_base`..`pf_limit`, inclusive. A claimed memory request reports `rsp_class` = 1.
- R3: VGA memory window. When both `vga_en` and `mem_en` are 1, host addresses 0A_0000h..0B_FFFFh are claimed as memory, whatever the base/limit windows hold.
- R4: Memory command and address. A claimed memory read gives `rsp_cmd` = 4'b0110 and a claimed memory write gives 4'b0111. `rsp_addr` equals the host address unchanged. Prefetchable and plain hits give identical results.
- R5: Dual-address flag. `rsp_dac` is 1 exactly when a claimed memory address has a nonzero bit in 39:32.
- R6: I/O claim and translation. Host addresses FD_FC00_0000h..FD_FDFF_FFFFh form the I/O aperture. The I/O address is host bits 24:0, zero-extended. The request is claimed when `io_en` is 1 and the I/O address lies in `io_base`..`io_limit`, inclusive. The response gives `rsp_class` = 2, and `rsp_addr` holds the I/O address with bits 39:25 equal to 0.
- R7: ISA holes. When `isa_en` is 1, an I/O address below 10000h whose bits 9:8 are nonzero is not claimed through the base/limit window.
- R8: VGA I/O window. When both `vga_en` and `io_en` are 1, an I/O address below 10000h whose bits 9:0 lie in 3B0h..3BBh or 3C0h..3DFh is claimed. This holds even inside an ISA hole and outside the base/limit window.
- R9: I/O command. A claimed I/O read gives `rsp_cmd` = 4'b0010 and a claimed I/O write gives 4'b0011.
- R10: Own configuration claim. Host addresses FD_FE00_0000h..FD_FFFF_FFFFh form the configuration aperture. A request there is claimed only when bit 24 is 0 (Type 0) and bits 15:11 equal `unit_id`. The response gives `rsp_class` = 3, `rsp_cmd` = 0 and `rsp_addr` = host bits 7:0, zero-extended. Type 1 requests and requests with a mismatched device number are not claimed.
- R11: Rejection. Several kinds of request are not claimed: any other host address, a memory or I/O address outside every enabled window, and any request whose space enable is 0. For each of these, `rsp_valid` is 1 while `rsp_accept`, `rsp_class`, `rsp_cmd`, `rsp_addr` and `rsp_dac` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 40 | Host-side request address |
| req_write | input | 1 | 1 = sized write, 0 = sized read |
| mem_en | input | 1 | Memory space enable |
| io_en | input | 1 | I/O space enable |
| isa_en | input | 1 | ISA alias holes enable |
| vga_en | input | 1 | Legacy VGA windows enable |
| mem_base | input | 32 | Memory window lower bound (inclusive) |
| mem_limit | input | 32 | Memory window upper bound (inclusive) |
| pf_base | input | 64 | Prefetchable window lower bound (inclusive) |
| pf_limit | input | 64 | Prefetchable window upper bound (inclusive) |
| io_base | input | 32 | I/O window lower bound, upper extension included |
| io_limit | input | 32 | I/O window upper bound, upper extension included |
| unit_id | input | 5 | Bridge's own device number |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_accept | output | 1 | Request claimed |
| rsp_class | output | 2 | 0 none, 1 memory, 2 I/O, 3 own config |
| rsp_cmd | output | 4 | Secondary-bus command code |
| rsp_addr | output | 40 | Translated address |
| rsp_dac | output | 1 | Dual address cycle needed |

## Verification
The hardest situations to reach are those where several I/O rules act on the same address. One is a VGA alias that falls inside an ISA hole and inside the base/limit window. Another is a VGA alias in an upper 1 KB block that is outside the window entirely. The stimulus programs the I/O window over 1000h..1FFFh with ISA holes on. It then steps through addresses in that block: ones at the hole edges, ones just inside and just outside the VGA ranges, and an alias at 7C0h. This separates hole rejection from VGA precedence. The aperture ends also need deliberate placement. The prefetchable window is stretched past FC_FFFF_FFFFh so that only the aperture bound rejects the next address, and the I/O window is moved to the top of the 25-bit space.

// File: rtl/dsd_pkg.sv
// Shared types and constants for the downstream address decoder.
// Assumes a 40-bit host address; aperture prefixes are defined on bits 39:25.
package dsd_pkg;

    typedef enum logic [1:0] {
        TGT_NONE     = 2'd0,
        TGT_MEM      = 2'd1,
        TGT_IO       = 2'd2,
        TGT_SELF_CFG = 2'd3
    } tgt_e;

    localparam logic [3:0] CMD_NONE   = 4'h0;
    localparam logic [3:0] CMD_IO_RD  = 4'h2;
    localparam logic [3:0] CMD_IO_WR  = 4'h3;
    localparam logic [3:0] CMD_MEM_RD = 4'h6;
    localparam logic [3:0] CMD_MEM_WR = 4'h7;

    // Highest value of address bits 39:32 still inside the memory aperture.
    localparam logic [7:0]  MEM_TOP_BYTE = 8'hFC;
    // Address bits 39:25 that select the I/O and configuration apertures.
    localparam logic [14:0] IO_PREFIX  = {8'hFD, 7'h7E};
    localparam logic [14:0] CFG_PREFIX = {8'hFD, 7'h7F};

    // Legacy VGA frame-buffer window in memory space.
    localparam logic [19:0] VGA_MEM_LO = 20'hA_0000;
    localparam logic [19:0] VGA_MEM_HI = 20'hB_FFFF;

endpackage

// File: rtl/dsd_mem_match.sv
// Memory aperture matcher.
// Claims an address below the memory aperture top when memory space is enabled
// and the address hits the 32-bit window, the 64-bit prefetchable window or the
// VGA frame-buffer window. Purely combinational; assumes AW is at least 32.
module dsd_mem_match
    import dsd_pkg::*;
#(
    parameter int AW    = 40,
    parameter int LOW_W = 32
) (
    input  logic [AW-1:0]    addr,
    input  logic             mem_en,
    input  logic             vga_en,
    input  logic [LOW_W-1:0] win_base,
    input  logic [LOW_W-1:0] win_limit,
    input  logic [63:0]      pf_base,
    input  logic [63:0]      pf_limit,
    output logic             hit,
    output logic             dac
);
    localparam int TOP_LSB = AW - 8;

    logic        in_aperture;
    logic        below_4g;
    logic        win_hit;
    logic        pf_hit;
    logic        vga_hit;
    logic [63:0] addr_ext;

    // Evaluate each memory window and merge them under the space enable.
    always_comb begin
        addr_ext    = {{(64-AW){1'b0}}, addr};
        in_aperture = addr[AW-1:TOP_LSB] <= MEM_TOP_BYTE;
        below_4g    = addr[AW-1:LOW_W] == '0;
        win_hit     = below_4g && (addr[LOW_W-1:0] >= win_base)
                               && (addr[LOW_W-1:0] <= win_limit);
        pf_hit      = (addr_ext >= pf_base) && (addr_ext <= pf_limit);
        vga_hit     = vga_en && (addr >= AW'(VGA_MEM_LO)) && (addr <= AW'(VGA_MEM_HI));
        hit         = mem_en && in_aperture && (win_hit || pf_hit || vga_hit);
        dac         = !below_4g;
    end

endmodule

// File: rtl/dsd_io_match.sv
// I/O aperture matcher.
// Strips the host address down to its pass-through bits and claims it through the
// base/limit window (minus ISA alias holes) or through the VGA register aliases.
// Purely combinational; assumes PASS_W is at least 16.
module dsd_io_match
    import dsd_pkg::*;
#(
    parameter int AW     = 40,
    parameter int PASS_W = 25,
    parameter int WIN_W  = 32
) (
    input  logic [AW-1:0]    addr,
    input  logic             io_en,
    input  logic             isa_en,
    input  logic             vga_en,
    input  logic [WIN_W-1:0] win_base,
    input  logic [WIN_W-1:0] win_limit,
    output logic             hit,
    output logic [AW-1:0]    io_addr
);
    localparam int PFX_W = AW - PASS_W;

    logic             in_aperture;
    logic [WIN_W-1:0] offset;
    logic [9:0]       lo10;
    logic             low_64k;
    logic             isa_hole;
    logic             win_hit;
    logic             vga_hit;

    // Translate the address and apply window, hole and VGA alias rules.
    always_comb begin
        in_aperture = addr[AW-1:PASS_W] == PFX_W'(IO_PREFIX);
        offset      = {{(WIN_W-PASS_W){1'b0}}, addr[PASS_W-1:0]};
        lo10        = offset[9:0];
        low_64k     = offset[WIN_W-1:16] == '0;
        isa_hole    = isa_en && low_64k && (offset[9:8] != 2'b00);
        win_hit     = (offset >= win_base) && (offset <= win_limit) && !isa_hole;
        vga_hit     = vga_en && low_64k &&
                      (((lo10 >= 10'h3B0) && (lo10 <= 10'h3BB)) ||
                       ((lo10 >= 10'h3C0) && (lo10 <= 10'h3DF)));
        hit         = io_en && in_aperture && (win_hit || vga_hit);
        io_addr     = {{PFX_W{1'b0}}, addr[PASS_W-1:0]};
    end

endmodule

// File: rtl/dsd_cfg_match.sv
// Configuration aperture matcher.
// Claims Type 0 requests whose device number equals the bridge's unit ID and
// yields the register offset inside the bridge's own configuration space.
// Purely combinational.
module dsd_cfg_match
    import dsd_pkg::*;
#(
    parameter int AW     = 40,
    parameter int PASS_W = 25,
    parameter int UNIT_W = 5,
    parameter int OFS_W  = 8
) (
    input  logic [AW-1:0]     addr,
    input  logic [UNIT_W-1:0] unit_id,
    output logic              hit,
    output logic [AW-1:0]     reg_addr
);
    localparam int PFX_W   = AW - PASS_W;
    localparam int TYPE_B  = PASS_W - 1;
    localparam int DEV_LSB = 11;

    logic in_aperture;
    logic type1;
    logic dev_match;

    // Check aperture, request type and device number.
    always_comb begin
        in_aperture = addr[AW-1:PASS_W] == PFX_W'(CFG_PREFIX);
        type1       = addr[TYPE_B];
        dev_match   = addr[DEV_LSB+UNIT_W-1:DEV_LSB] == unit_id;
        hit         = in_aperture && !type1 && dev_match;
        reg_addr    = {{(AW-OFS_W){1'b0}}, addr[OFS_W-1:0]};
    end

endmodule

// File: rtl/dsd_addr_decoder.sv
// Downstream address decoder, top level.
// Runs the memory, I/O and configuration matchers in parallel on each request,
// selects the single claiming aperture (the apertures are disjoint) and registers
// accept, class, command, address and dual-address flag for one cycle.
// Assumes the configuration inputs are stable while a request is presented.
module dsd_addr_decoder
    import dsd_pkg::*;
#(
    parameter int AW     = 40,
    parameter int LOW_W  = 32,
    parameter int PASS_W = 25,
    parameter int UNIT_W = 5,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_write,
    input  logic              mem_en,
    input  logic              io_en,
    input  logic              isa_en,
    input  logic              vga_en,
    input  logic [LOW_W-1:0]  mem_base,
    input  logic [LOW_W-1:0]  mem_limit,
    input  logic [63:0]       pf_base,
    input  logic [63:0]       pf_limit,
    input  logic [LOW_W-1:0]  io_base,
    input  logic [LOW_W-1:0]  io_limit,
    input  logic [UNIT_W-1:0] unit_id,
    output logic              rsp_valid,
    output logic              rsp_accept,
    output logic [1:0]        rsp_class,
    output logic [3:0]        rsp_cmd,
    output logic [AW-1:0]     rsp_addr,
    output logic              rsp_dac
);
    logic          mem_hit;
    logic          mem_dac;
    logic          io_hit;
    logic [AW-1:0] io_addr;
    logic          cfg_hit;
    logic [AW-1:0] cfg_addr;

    logic          nx_accept;
    tgt_e          nx_class;
    logic [3:0]    nx_cmd;
    logic [AW-1:0] nx_addr;
    logic          nx_dac;

    dsd_mem_match #(.AW(AW), .LOW_W(LOW_W)) u_mem (
        .addr      (req_addr),
        .mem_en    (mem_en),
        .vga_en    (vga_en),
        .win_base  (mem_base),
        .win_limit (mem_limit),
        .pf_base   (pf_base),
        .pf_limit  (pf_limit),
        .hit       (mem_hit),
        .dac       (mem_dac)
    );

    dsd_io_match #(.AW(AW), .PASS_W(PASS_W), .WIN_W(LOW_W)) u_io (
        .addr      (req_addr),
        .io_en     (io_en),
        .isa_en    (isa_en),
        .vga_en    (vga_en),
        .win_base  (io_base),
        .win_limit (io_limit),
        .hit       (io_hit),
        .io_addr   (io_addr)
    );

    dsd_cfg_match #(.AW(AW), .PASS_W(PASS_W), .UNIT_W(UNIT_W), .OFS_W(OFS_W)) u_cfg (
        .addr      (req_addr),
        .unit_id   (unit_id),
        .hit       (cfg_hit),
        .reg_addr  (cfg_addr)
    );

    // Pick the claiming aperture and form its command and address.
    always_comb begin
        nx_accept = 1'b0;
        nx_class  = TGT_NONE;
        nx_cmd    = CMD_NONE;
        nx_addr   = '0;
        nx_dac    = 1'b0;
        if (req_valid) begin
            if (mem_hit) begin
                nx_accept = 1'b1;
                nx_class  = TGT_MEM;
                nx_cmd    = req_write ? CMD_MEM_WR : CMD_MEM_RD;
                nx_addr   = req_addr;
                nx_dac    = mem_dac;
            end else if (io_hit) begin
                nx_accept = 1'b1;
                nx_class  = TGT_IO;
                nx_cmd    = req_write ? CMD_IO_WR : CMD_IO_RD;
                nx_addr   = io_addr;
            end else if (cfg_hit) begin
                nx_accept = 1'b1;
                nx_class  = TGT_SELF_CFG;
                nx_addr   = cfg_addr;
            end
        end
    end

    // Register the decision one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_accept <= 1'b0;
            rsp_class  <= 2'd0;
            rsp_cmd    <= CMD_NONE;
            rsp_addr   <= '0;
            rsp_dac    <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_accept <= nx_accept;
            rsp_class  <= nx_class;
            rsp_cmd    <= nx_cmd;
            rsp_addr   <= nx_addr;
            rsp_dac    <= nx_dac;
        end
    end

    // R1: a request yields a result pulse on the next cycle.
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1: no request means a quiet result on the next cycle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_accept));

    // R4: a claimed memory access carries a memory command.
    p_mem_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_accept && rsp_class == 2'd1) |-> (rsp_cmd == CMD_MEM_RD || rsp_cmd == CMD_MEM_WR));

    // R5: the dual-address flag appears only on claimed memory results.
    p_dac_mem_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_dac |-> (rsp_accept && rsp_class == 2'd1));

    // R6: translated I/O addresses carry nothing above the pass-through bits.
    p_io_addr_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_accept && rsp_class == 2'd2) |-> (rsp_addr[AW-1:PASS_W] == '0));

    // R9: a claimed I/O access carries an I/O command.
    p_io_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_accept && rsp_class == 2'd2) |-> (rsp_cmd == CMD_IO_RD || rsp_cmd == CMD_IO_WR));

    // R10: own configuration hits issue no secondary-bus command.
    p_cfg_no_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_class == 2'd3) |-> (rsp_cmd == CMD_NONE && rsp_accept));

    // R11: a rejected result has every field cleared.
    p_reject_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_accept) |->
        (rsp_class == 2'd0 && rsp_cmd == CMD_NONE && rsp_addr == '0 && !rsp_dac));

endmodule

// File: tb/tb_dsd_addr_decoder.sv
module tb_dsd_addr_decoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [39:0] req_addr;
    logic        req_write;
    logic        mem_en, io_en, isa_en, vga_en;
    logic [31:0] mem_base, mem_limit, io_base, io_limit;
    logic [63:0] pf_base, pf_limit;
    logic [4:0]  unit_id;
    logic        rsp_valid, rsp_accept, rsp_dac;
    logic [1:0]  rsp_class;
    logic [3:0]  rsp_cmd;
    logic [39:0] rsp_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    dsd_addr_decoder dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .mem_en(mem_en), .io_en(io_en), .isa_en(isa_en),
        .vga_en(vga_en), .mem_base(mem_base), .mem_limit(mem_limit),
        .pf_base(pf_base), .pf_limit(pf_limit), .io_base(io_base), .io_limit(io_limit),
        .unit_id(unit_id), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
        .rsp_class(rsp_class), .rsp_cmd(rsp_cmd), .rsp_addr(rsp_addr), .rsp_dac(rsp_dac)
    );

    // Compare the whole result bundle against the expected one.
    task automatic expect_rsp(input string tag, input logic v, input logic acc,
                              input logic [1:0] cls, input logic [3:0] cmd,
                              input logic [39:0] a, input logic dac);
        logic [48:0] got, exp;
        got = {rsp_valid, rsp_accept, rsp_class, rsp_cmd, rsp_addr, rsp_dac};
        exp = {v, acc, cls, cmd, a, dac};
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got v=%b acc=%b cls=%0d cmd=%h addr=%h dac=%b, exp v=%b acc=%b cls=%0d cmd=%h addr=%h dac=%b",
                     tag, rsp_valid, rsp_accept, rsp_class, rsp_cmd, rsp_addr, rsp_dac,
                     v, acc, cls, cmd, a, dac);
        end
    endtask

    // Present one request for a single cycle; results are readable on return.
    task automatic issue(input logic [39:0] a, input logic wr);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = '0;
        req_write = 1'b0;
    endtask

    task automatic claim(input string tag, input logic [39:0] a, input logic wr,
                         input logic [1:0] cls, input logic [3:0] cmd,
                         input logic [39:0] out_a, input logic dac);
        issue(a, wr);
        expect_rsp(tag, 1'b1, 1'b1, cls, cmd, out_a, dac);
    endtask

    task automatic reject(input string tag, input logic [39:0] a, input logic wr);
        issue(a, wr);
        expect_rsp(tag, 1'b1, 1'b0, 2'd0, 4'h0, 40'h0, 1'b0);
    endtask

    task automatic set_defaults();
        mem_en = 1'b1; io_en = 1'b1; isa_en = 1'b0; vga_en = 1'b0;
        mem_base  = 32'h8000_0000; mem_limit = 32'h8FFF_FFFF;
        pf_base   = 64'h1_0000_0000; pf_limit = 64'h3_FFFF_FFFF;
        io_base   = 32'h0000_1000; io_limit = 32'h0000_1FFF;
        unit_id   = 5'd3;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req_valid = 1'b1; req_addr = 40'h80_0000_0000; req_write = 1'b0;
        set_defaults();
        repeat (3) @(negedge clk);
        expect_rsp("R1 reset clears outputs", 0, 0, 2'd0, 4'h0, 40'h0, 0);
        req_valid = 1'b0; req_addr = '0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_valid_pulse();
        claim("R1 result one cycle after request", 40'h00_8000_0000, 1'b0, 2'd1, 4'h6, 40'h00_8000_0000, 0);
        @(negedge clk);
        expect_rsp("R1 idle cycle quiet", 0, 0, 2'd0, 4'h0, 40'h0, 0);
    endtask

    task automatic t_mem_window();
        reject("R2 below memory base", 40'h00_7FFF_FFFF, 1'b0);
        claim ("R2 memory base edge", 40'h00_8000_0000, 1'b1, 2'd1, 4'h7, 40'h00_8000_0000, 0);
        claim ("R4 memory limit edge read", 40'h00_8FFF_FFFF, 1'b0, 2'd1, 4'h6, 40'h00_8FFF_FFFF, 0);
        reject("R2 above memory limit", 40'h00_9000_0000, 1'b1);
    endtask

    task automatic t_prefetch_dac();
        reject("R5 just below 4 GB outside windows", 40'h00_FFFF_FFFF, 1'b0);
        claim ("R5 4 GB prefetch base with DAC", 40'h01_0000_0000, 1'b0, 2'd1, 4'h6, 40'h01_0000_0000, 1);
        claim ("R4 prefetch limit write", 40'h03_FFFF_FFFF, 1'b1, 2'd1, 4'h7, 40'h03_FFFF_FFFF, 1);
        reject("R2 above prefetch limit", 40'h04_0000_0000, 1'b0);
        pf_base = 64'hF0_0000_0000; pf_limit = 64'hFF_FFFF_FFFF;
        claim ("R2 memory aperture top", 40'hFC_FFFF_FFFF, 1'b0, 2'd1, 4'h6, 40'hFC_FFFF_FFFF, 1);
        reject("R11 above memory aperture", 40'hFD_0000_0000, 1'b0);
        reject("R11 above config aperture", 40'hFE_0000_0000, 1'b0);
        pf_base = 64'h1_0000_0000; pf_limit = 64'h3_FFFF_FFFF;
    endtask

    task automatic t_vga_mem();
        reject("R3 VGA memory off", 40'h00_000A_0000, 1'b0);
        vga_en = 1'b1;
        claim ("R3 VGA memory low edge", 40'h00_000A_0000, 1'b0, 2'd1, 4'h6, 40'h00_000A_0000, 0);
        claim ("R3 VGA memory high edge", 40'h00_000B_FFFF, 1'b1, 2'd1, 4'h7, 40'h00_000B_FFFF, 0);
        reject("R3 below VGA memory", 40'h00_0009_FFFF, 1'b0);
        reject("R3 above VGA memory", 40'h00_000C_0000, 1'b0);
        mem_en = 1'b0;
        reject("R3 VGA memory needs mem_en", 40'h00_000A_0000, 1'b0);
        vga_en = 1'b0;
    endtask

    task automatic t_mem_disable();
        mem_en = 1'b0;
        reject("R11 memory window with mem_en clear", 40'h00_8000_0000, 1'b0);
        reject("R11 prefetch window with mem_en clear", 40'h02_0000_0000, 1'b1);
        mem_en = 1'b1;
    endtask

    task automatic t_io_window();
        reject("R6 below I/O base", 40'hFD_FC00_0FFF, 1'b0);
        claim ("R6 I/O base edge", 40'hFD_FC00_1000, 1'b0, 2'd2, 4'h2, 40'h00_0000_1000, 0);
        claim ("R9 I/O limit edge write", 40'hFD_FC00_1FFF, 1'b1, 2'd2, 4'h3, 40'h00_0000_1FFF, 0);
        reject("R6 above I/O limit", 40'hFD_FC00_2000, 1'b0);
        reject("R11 below I/O aperture", 40'hFD_FBFF_1000, 1'b0);
        io_en = 1'b0;
        reject("R6 I/O window with io_en clear", 40'hFD_FC00_1000, 1'b0);
        io_en = 1'b1;
    endtask

    task automatic t_isa_holes();
        isa_en = 1'b1;
        claim ("R7 hole-free quarter kept", 40'hFD_FC00_10FF, 1'b0, 2'd2, 4'h2, 40'h00_0000_10FF, 0);
        reject("R7 first hole address", 40'hFD_FC00_1100, 1'b0);
        reject("R7 last hole address", 40'hFD_FC00_13FF, 1'b1);
        claim ("R7 next 1K block start", 40'hFD_FC00_1400, 1'b1, 2'd2, 4'h3, 40'h00_0000_1400, 0);
        isa_en = 1'b0;
        claim ("R7 hole address without isa_en", 40'hFD_FC00_1100, 1'b0, 2'd2, 4'h2, 40'h00_0000_1100, 0);
    endtask

    task automatic t_vga_io();
        reject("R8 VGA I/O off", 40'hFD_FC00_03B0, 1'b0);
        vga_en = 1'b1; isa_en = 1'b1;
        claim ("R8 VGA low range start", 40'hFD_FC00_03B0, 1'b0, 2'd2, 4'h2, 40'h00_0000_03B0, 0);
        claim ("R8 VGA low range end", 40'hFD_FC00_03BB, 1'b1, 2'd2, 4'h3, 40'h00_0000_03BB, 0);
        reject("R8 gap after low range", 40'hFD_FC00_03BC, 1'b0);
        claim ("R8 alias in upper 1K block", 40'hFD_FC00_07C0, 1'b0, 2'd2, 4'h2, 40'h00_0000_07C0, 0);
        claim ("R8 alias beats ISA hole", 40'hFD_FC00_13DF, 1'b0, 2'd2, 4'h2, 40'h00_0000_13DF, 0);
        reject("R7 hole just past VGA range", 40'hFD_FC00_13E0, 1'b0);
        reject("R8 alias above 64K", 40'hFD_FC01_03C0, 1'b0);
        io_en = 1'b0;
        reject("R8 VGA I/O needs io_en", 40'hFD_FC00_03C0, 1'b0);
        io_en = 1'b1; vga_en = 1'b0; isa_en = 1'b0;
    endtask

    task automatic t_io_high();
        io_base = 32'h0100_0000; io_limit = 32'h01FF_FFFF;
        claim ("R6 I/O aperture top", 40'hFD_FDFF_FFFF, 1'b1, 2'd2, 4'h3, 40'h00_01FF_FFFF, 0);
        claim ("R6 upper extension base", 40'hFD_FD00_0000, 1'b0, 2'd2, 4'h2, 40'h00_0100_0000, 0);
        io_base = 32'h0000_1000; io_limit = 32'h0000_1FFF;
    endtask

    task automatic t_cfg();
        claim ("R10 Type 0 own device", 40'hFD_FE00_1844, 1'b0, 2'd3, 4'h0, 40'h00_0000_0044, 0);
        claim ("R10 Type 0 own device write", 40'hFD_FE00_18FC, 1'b1, 2'd3, 4'h0, 40'h00_0000_00FC, 0);
        reject("R10 other device", 40'hFD_FE00_2044, 1'b0);
        reject("R10 Type 1 not claimed", 40'hFD_FF00_1844, 1'b0);
        reject("R10 config aperture top", 40'hFD_FFFF_FFFF, 1'b0);
        unit_id = 5'd0;
        claim ("R10 config aperture base", 40'hFD_FE00_0000, 1'b0, 2'd3, 4'h0, 40'h00_0000_0000, 0);
        unit_id = 5'd3;
    endtask

    initial begin
        t_reset();
        t_valid_pulse();
        t_mem_window();
        t_prefetch_dac();
        t_vga_mem();
        set_defaults();
        t_mem_disable();
        t_io_window();
        t_isa_holes();
        t_vga_io();
        t_io_high();
        t_cfg();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule